// File: doc/BRIEF.md
# Configurable Input Edge Conditioner

This block takes a group of asynchronous general-purpose logic pins and turns each one into a clean, clock-aligned control signal for downstream sequencing logic. Every pin first passes through a two-flop synchroniser. Each channel has its own mode, set independently of the others.

A channel in buffer mode passes the synchronised pin through, either as is or inverted. In an edge mode it watches for a rising or a falling transition. A detected edge then drives the output in one of two ways. It can make a pulse that lasts a programmable number of millisecond ticks. It can also set a latched level that stays high until a clear strobe arrives.

A shared tick divider produces the millisecond time base. Any change to a channel's mode discards that channel's pulse count and latched level, so the outputs never carry stale history from an earlier configuration.

Top module: `input_edge_conditioner`

## Requirements
- R1: Reset clears every synchroniser, pulse counter and latched level; directly after reset a channel in buffer or edge mode outputs 0 and a channel in inverted-buffer mode outputs 1.
- R2: With source field 00 (bits [2i+1:2i] of `modeSrc`), `condOut[i]` equals the pin value sampled two clock edges earlier.
- R3: With source field 11, `condOut[i]` equals the complement of the pin value sampled two clock edges earlier.
- R4: With source field 01 or 10 and `modeLevel[i]`=0 (pulse), a matching edge drives the output high for between (L-1)*T+1 and L*T cycles, where L is `pulseLen[8i+7:8i]` (0 is treated as 1) and T is `TICK_CYCLES`.
- R5: With source field 01 or 10 and `modeLevel[i]`=1 (level), a matching edge sets the output high, and it stays high until a clear strobe, a mode change or reset.
- R6: `clearLvl[i]` clears a latched level, so the output is 0 in the following cycle and the clear wins over an edge in the same cycle; in buffer and pulse modes the strobe has no effect.
- R7: Source field 01 reacts only to rising pin edges and 10 only to falling ones; the output reacts on the third clock edge after the pin change.
- R8: Any change of a channel's source field or level bit clears that channel's pulse counter and latched level, and drops an edge detected in the same cycle.
- R9: An edge that arrives while a pulse is running restarts the pulse count at the full length L.
- R10: Channels are independent; stimulus, modes and strobes on one channel do not change another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NUM_CH | Asynchronous general-purpose pins |
| modeSrc | input | 2*NUM_CH | Per-channel source select: 00 buffer, 01 rising, 10 falling, 11 inverted buffer |
| modeLevel | input | NUM_CH | Per-channel edge output style: 0 pulse, 1 latched level |
| pulseLen | input | LEN_W*NUM_CH | Per-channel pulse length in ticks |
| clearLvl | input | NUM_CH | Per-channel latched-level clear strobe |
| condOut | output | NUM_CH | Conditioned outputs |

## Verification
The hardest case to reach from the ports is the exact pulse width. The width depends on where the edge falls against the free-running tick divider, and the bench cannot see that phase. So the bench sweeps several pulse lengths, counts the high cycles at the output, and checks the count against the arithmetic window from R4.

A retriggered pulse is created by giving a second edge before the first pulse can end. The output is then sampled just after the first pulse's latest possible end.

Each channel is also walked through all eight mode codes with a rise, fall and clear sequence. The other channels are held idle and observed, which checks that they stay independent.

// File: rtl/ic_pkg.sv
package ic_pkg;
  typedef enum logic [1:0] {
    SRC_BUF  = 2'b00,
    SRC_RISE = 2'b01,
    SRC_FALL = 2'b10,
    SRC_INV  = 2'b11
  } srcSel_t;

  typedef struct packed {
    logic fire;    // matching edge seen, mode unchanged
    logic wipe;    // mode changed: clear all channel state
    logic clrLvl;  // clear latched level
  } chStrobe_t;
endpackage

// File: rtl/ic_sync.sv
module ic_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/ic_ctrl.sv
module ic_ctrl
  import ic_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int TICK_CYCLES = 50000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CH-1:0]            syncIn,
  input  logic [2*NUM_CH-1:0]          modeSrc,
  input  logic [NUM_CH-1:0]            modeLevel,
  input  logic [NUM_CH-1:0]            clearLvl,
  output chStrobe_t [NUM_CH-1:0]       strobes,
  output logic                         tick
);
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYCLES - 1);

  logic [TW-1:0]     tickCnt;
  logic [NUM_CH-1:0] prevIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      prevIn  <= '0;
    end else begin
      tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + 1'b1;
      prevIn  <= syncIn;
    end
  end

  assign tick = (tickCnt == TICK_LAST);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [2:0] modeNow, modePrev;
    logic       modeChg, riseSeen, fallSeen;
    srcSel_t    src;

    assign src      = srcSel_t'(modeSrc[2*ch +: 2]);
    assign modeNow  = {modeLevel[ch], modeSrc[2*ch +: 2]};
    assign modeChg  = (modeNow != modePrev);
    assign riseSeen = syncIn[ch] & ~prevIn[ch];
    assign fallSeen = ~syncIn[ch] & prevIn[ch];

    always_ff @(posedge clk) begin
      if (!rstN) modePrev <= '0;
      else       modePrev <= modeNow;
    end

    always_comb begin
      strobes[ch].wipe   = modeChg;
      strobes[ch].clrLvl = clearLvl[ch];
      unique case (src)
        SRC_RISE: strobes[ch].fire = riseSeen & ~modeChg;
        SRC_FALL: strobes[ch].fire = fallSeen & ~modeChg;
        default:  strobes[ch].fire = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ic_datapath.sv
module ic_datapath
  import ic_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LEN_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       syncIn,
  input  logic [2*NUM_CH-1:0]     modeSrc,
  input  logic [NUM_CH-1:0]       modeLevel,
  input  logic [LEN_W*NUM_CH-1:0] pulseLen,
  input  chStrobe_t [NUM_CH-1:0]  strobes,
  input  logic                    tick,
  output logic [NUM_CH-1:0]       condOut
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [LEN_W-1:0] remain, lenRaw, lenEff;
    logic             latched;
    srcSel_t          src;

    assign src    = srcSel_t'(modeSrc[2*ch +: 2]);
    assign lenRaw = pulseLen[LEN_W*ch +: LEN_W];
    assign lenEff = (lenRaw == '0) ? LEN_W'(1) : lenRaw;

    always_ff @(posedge clk) begin
      if (!rstN)                                remain <= '0;
      else if (strobes[ch].wipe)                remain <= '0;
      else if (strobes[ch].fire && !modeLevel[ch]) remain <= lenEff;
      else if (tick && remain != '0)            remain <= remain - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                                     latched <= 1'b0;
      else if (strobes[ch].wipe || strobes[ch].clrLvl) latched <= 1'b0;
      else if (strobes[ch].fire && modeLevel[ch])    latched <= 1'b1;
    end

    always_comb begin
      unique case (src)
        SRC_BUF: condOut[ch] = syncIn[ch];
        SRC_INV: condOut[ch] = ~syncIn[ch];
        default: condOut[ch] = modeLevel[ch] ? latched : (remain != '0);
      endcase
    end
  end
endmodule

// File: rtl/input_edge_conditioner.sv
module input_edge_conditioner
  import ic_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int LEN_W       = 8,
  parameter int TICK_CYCLES = 50000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       pinIn,
  input  logic [2*NUM_CH-1:0]     modeSrc,
  input  logic [NUM_CH-1:0]       modeLevel,
  input  logic [LEN_W*NUM_CH-1:0] pulseLen,
  input  logic [NUM_CH-1:0]       clearLvl,
  output logic [NUM_CH-1:0]       condOut
);
  logic [NUM_CH-1:0]      syncIn;
  chStrobe_t [NUM_CH-1:0] strobes;
  logic                   tick;

  ic_sync #(.WIDTH(NUM_CH)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(syncIn)
  );

  ic_ctrl #(.NUM_CH(NUM_CH), .TICK_CYCLES(TICK_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .modeSrc(modeSrc),
    .modeLevel(modeLevel), .clearLvl(clearLvl), .strobes(strobes), .tick(tick)
  );

  ic_datapath #(.NUM_CH(NUM_CH), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .modeSrc(modeSrc),
    .modeLevel(modeLevel), .pulseLen(pulseLen), .strobes(strobes),
    .tick(tick), .condOut(condOut)
  );
endmodule

// File: rtl/ic_checker.sv
module ic_checker #(
  parameter int NUM_CH = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_CH-1:0]   pinIn,
  input logic [2*NUM_CH-1:0] modeSrc,
  input logic [NUM_CH-1:0]   modeLevel,
  input logic [NUM_CH-1:0]   clearLvl,
  input logic [NUM_CH-1:0]   condOut,
  input logic                tick
);
  logic [1:0] sinceReset;
  logic       warm;

  always_ff @(posedge clk) begin
    if (!rstN)                  sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 1'b1;
  end
  assign warm = (sinceReset == 2'd3);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [2:0] modeNow;
    logic       edgeMode, lvlEdge, pulseEdge;
    assign modeNow   = {modeLevel[ch], modeSrc[2*ch +: 2]};
    assign edgeMode  = (modeSrc[2*ch +: 2] == 2'b01) || (modeSrc[2*ch +: 2] == 2'b10);
    assign lvlEdge   = edgeMode && modeLevel[ch];
    assign pulseEdge = edgeMode && !modeLevel[ch];

    assert_buffer_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
      (warm && modeSrc[2*ch +: 2] == 2'b00) |-> (condOut[ch] == $past(pinIn[ch], 2)));

    assert_inverted_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
      (warm && modeSrc[2*ch +: 2] == 2'b11) |-> (condOut[ch] == !$past(pinIn[ch], 2)));

    assert_pulse_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
      (warm && pulseEdge && condOut[ch] && !tick && modeNow == $past(modeNow))
      |=> (condOut[ch] || modeNow != $past(modeNow)));

    assert_level_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
      (warm && lvlEdge && condOut[ch] && !clearLvl[ch] && modeNow == $past(modeNow))
      |=> (condOut[ch] || modeNow != $past(modeNow)));

    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rstN)
      (warm && lvlEdge && clearLvl[ch])
      |=> (!condOut[ch] || modeNow != $past(modeNow)));

    assert_mode_change_wipes_R8: assert property (@(posedge clk) disable iff (!rstN)
      (warm && modeNow != $past(modeNow))
      |=> (!condOut[ch] || !edgeMode || modeNow != $past(modeNow)));
  end
endmodule

bind input_edge_conditioner ic_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .pinIn(pinIn), .modeSrc(modeSrc),
  .modeLevel(modeLevel), .clearLvl(clearLvl), .condOut(condOut), .tick(tick)
);

// File: tb/tb_input_edge_conditioner.sv
module tb_input_edge_conditioner;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 4;
  localparam int LEN_W      = 8;
  localparam int TICK       = 4;

  logic                    clk = 1'b0;
  logic                    rstN;
  logic [NUM_CH-1:0]       pinIn;
  logic [2*NUM_CH-1:0]     modeSrc;
  logic [NUM_CH-1:0]       modeLevel;
  logic [LEN_W*NUM_CH-1:0] pulseLen;
  logic [NUM_CH-1:0]       clearLvl;
  logic [NUM_CH-1:0]       condOut;

  int checks = 0;
  int errors = 0;

  input_edge_conditioner #(.NUM_CH(NUM_CH), .LEN_W(LEN_W), .TICK_CYCLES(TICK)) dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .modeSrc(modeSrc), .modeLevel(modeLevel),
    .pulseLen(pulseLen), .clearLvl(clearLvl), .condOut(condOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [NUM_CH-1:0] act, input logic [NUM_CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  // Expected channel output during the sweep: ph 0 idle, 1 after rise, 2 after fall, 3 after clear
  function automatic logic expCh(input int src, input int lv, input int ph);
    case (src)
      0: return ph == 1;
      3: return ph != 1;
      1: return (ph == 0) ? 1'b0 : ((lv != 0 && ph == 3) ? 1'b0 : 1'b1);
      default: return (ph <= 1) ? 1'b0 : ((lv != 0 && ph == 3) ? 1'b0 : 1'b1);
    endcase
  endfunction

  function automatic string tagFor(input int src, input int lv);
    if (src == 0) return "R2/R10";
    if (src == 3) return "R3/R10";
    if (lv != 0)  return "R5/R6/R7/R10";
    return "R4/R6/R7/R10";
  endfunction

  task automatic measurePulse(input int len);
    int width = 0;
    int wait0 = 0;
    int lEff;
    lEff = (len == 0) ? 1 : len;
    pulseLen[LEN_W*2 +: LEN_W] = LEN_W'(len);
    pinIn[2] = 1'b1;
    while (!condOut[2] && wait0 < 10) begin waitN(1); wait0++; end
    while (condOut[2] && width < 2000) begin waitN(1); width++; end
    checks++;
    if (width < (lEff-1)*TICK+1 || width > lEff*TICK) begin
      errors++;
      $display("FAIL R4 len %0d actual width %0d expected %0d..%0d",
               len, width, (lEff-1)*TICK+1, lEff*TICK);
    end
    pinIn[2] = 1'b0;
    waitN(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN      = 1'b0;
    pinIn     = '0;
    modeSrc   = 8'b11_00_00_00;
    modeLevel = '0;
    pulseLen  = {NUM_CH{8'd200}};
    clearLvl  = '0;
    waitN(3);
    rstN = 1'b1;
    check("R1 reset state", condOut, 4'b1000);
    modeSrc = '0;
    waitN(3);
    check("R1 idle after reset", condOut, 4'b0000);

    // Sweep every channel through all eight mode codes
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int m = 0; m < 8; m++) begin
        logic [NUM_CH-1:0] exp;
        int src, lv;
        src = m % 4;
        lv  = m / 4;
        pinIn = '0;
        modeSrc[2*ch +: 2] = 2'(src);
        modeLevel[ch] = 1'(lv);
        waitN(4);
        for (int ph = 0; ph < 4; ph++) begin
          if (ph == 1) begin pinIn[ch] = 1'b1; waitN(4); end
          if (ph == 2) begin pinIn[ch] = 1'b0; waitN(4); end
          if (ph == 3) begin clearLvl[ch] = 1'b1; waitN(1); clearLvl[ch] = 1'b0; waitN(2); end
          exp = '0;
          exp[ch] = expCh(src, lv, ph);
          check($sformatf("%s ch%0d mode%0d ph%0d", tagFor(src, lv), ch, m, ph), condOut, exp);
        end
        modeSrc[2*ch +: 2] = 2'b00;
        modeLevel[ch] = 1'b0;
        waitN(3);
        check($sformatf("R8 ch%0d mode%0d restored", ch, m), condOut, 4'b0000);
      end
    end

    // R4: pulse width window across lengths, including 0 as 1 and the maximum
    modeSrc[2*2 +: 2] = 2'b01;
    modeLevel[2] = 1'b0;
    waitN(3);
    measurePulse(0);
    measurePulse(1);
    measurePulse(2);
    measurePulse(3);
    measurePulse(7);
    measurePulse(255);

    // R9: second edge during a pulse restarts the count
    pulseLen[LEN_W*2 +: LEN_W] = 8'd3;
    pinIn[2] = 1'b1; waitN(4);
    pinIn[2] = 1'b0; waitN(2);
    pinIn[2] = 1'b1; waitN(10);
    check("R9 retriggered pulse still high", condOut, 4'b0100);
    waitN(20);
    check("R9 retriggered pulse ends", condOut, 4'b0000);
    pinIn[2] = 1'b0;
    modeSrc[2*2 +: 2] = 2'b00;
    waitN(3);

    // R8: switching edge polarity drops a latched level; R7 falling edge then sets it
    modeSrc[2*1 +: 2] = 2'b01;
    modeLevel[1] = 1'b1;
    waitN(3);
    pinIn[1] = 1'b1; waitN(4);
    check("R5 latched on rise", condOut, 4'b0010);
    modeSrc[2*1 +: 2] = 2'b10;
    waitN(2);
    check("R8 mode change clears level", condOut, 4'b0000);
    pinIn[1] = 1'b0; waitN(4);
    check("R7 falling edge sets level", condOut, 4'b0010);
    modeLevel[1] = 1'b0;
    waitN(2);
    check("R8 level bit change clears", condOut, 4'b0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule